// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator with Line-Locked Frequency Override

This block produces the running phase of a colour subcarrier with a phase-accumulator direct digital synthesizer. A 32-bit increment is added to a 32-bit accumulator on every clock. Software programs the increment as four byte registers. The output is the raw accumulator value. A downstream sine/cosine stage turns it into a carrier.

A two-bit mode input sets what a shared serial pin does. In the plain modes the pin is ignored. In the subcarrier-reset mode, a falling edge on the pin arms a phase restart, and the restart happens at the next field start. In the real-time control mode, an external video decoder sends frames over the pin. Each frame carries a 22-bit frequency value. The value replaces the programmed increment at the next line start, so the carrier follows the decoder's line-length changes line by line.

Top module: `scdds_top`

## Requirements
- R1: While reset is low, `phaseOut` is 0. After reset the programmed increment is `RESET_WORD` (default 0), no restart is armed and no received frame is pending.
- R2: Register address 0 holds increment bits 7:0, address 1 bits 15:8, address 2 bits 23:16 and address 3 bits 31:24. Writes to addresses 0 to 2 are only staged and do not change the increment.
- R3: A write to address 3 commits all 32 bits at once: its own byte together with the staged bytes from the most recent writes to addresses 0 to 2. The new increment is used from the clock edge after the one that samples the write.
- R4: On every clock that is not a restart, `phaseOut` advances by the active increment, modulo 2^32.
- R5: The mode encoding is 00 normal, 01 subcarrier reset, 10 real-time control and 11 normal. In the normal modes, pin edges, `fieldStart` and `lineStart` have no effect on the phase.
- R6: In mode 01, a high-to-low transition of `serialPin` arms a restart. At the next clock that samples `fieldStart` high, the phase is loaded with 0 instead of advancing, and counting resumes from 0 after that. A `fieldStart` with no armed restart has no effect.
- R7: In mode 01, a falling edge sampled in the same clock as `fieldStart` does not restart that field. It arms the restart for the following field start. A restart that was already armed still fires in that clock.
- R8: In mode 10, a frame begins with a rise of `serialPin` after at least `IDLE_MIN` (default 4) consecutive low clocks. A start marker two clocks long follows. Then come 67 bits, two clocks each, least significant bit first. Frame bits 0 to 21 are the frequency value V, and the active increment becomes V shifted left by 10 (low bits zero).
- R9: A received value takes effect only at the next clock that samples `lineStart` high. Until then the previous increment stays active. Before any value is applied in mode 10, the programmed increment is used.
- R10: In mode 10, a rise that follows fewer than `IDLE_MIN` low clocks starts no frame.
- R11: Leaving mode 10 at once restores the programmed increment and discards any received value, whether pending or applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Byte register address |
| regWrData | input | 8 | Byte register write data |
| modeSel | input | 2 | Pin function select |
| serialPin | input | 1 | Shared restart/serial-frame pin, synchronous to clk |
| fieldStart | input | 1 | Field boundary strobe |
| lineStart | input | 1 | Line boundary strobe |
| phaseOut | output | 32 | Accumulated subcarrier phase |

## Verification
Two functions can meet in one cycle: arming a restart from a pin fall, and acting on a field start. The bench drives the falling edge and `fieldStart` in the same clock twice, once with no restart armed and once with one already armed. It checks that the first case leaves the phase advancing and the second clears it. In both cases it also checks that the following field start clears the phase. A second overlap is a frame finishing while an earlier value is still active. The bench checks that the old increment holds until `lineStart` arrives.

// File: rtl/scdds_pkg.sv
package scdds_pkg;
  localparam int ACC_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = ACC_W / BYTE_W;
  localparam int ADDR_W    = $clog2(NUM_BYTES);
  localparam int FREQ_W    = 22;
  localparam int PAD_W     = ACC_W - FREQ_W;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_SCRESET = 2'b01,
    MODE_RTC     = 2'b10,
    MODE_ALT     = 2'b11
  } modeT;

  typedef struct packed {
    logic              commit;
    logic [ACC_W-1:0]  word;
    logic              phaseClear;
    logic              rtcApply;
    logic [FREQ_W-1:0] rtcFreq;
    logic              useRtc;
  } strobeT;
endpackage

// File: rtl/scdds_ctrl.sv
module scdds_ctrl
  import scdds_pkg::*;
#(
  parameter int IDLE_MIN   = 4,
  parameter int FRAME_BITS = 67
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic [1:0]        modeSel,
  input  logic              serialPin,
  input  logic              fieldStart,
  input  logic              lineStart,
  output strobeT            str
);
  localparam int IDX_W  = $clog2(FRAME_BITS + 1);
  localparam int LOW_W  = $clog2(IDLE_MIN + 1);
  localparam int FIDX_W = $clog2(FREQ_W);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rxStateT;

  modeT mode;
  logic isRtc, isRst;
  logic prevPin, fallEdge, riseEdge;
  logic armed;
  rxStateT rxState;
  logic halfTog;
  logic [IDX_W-1:0] bitIdx;
  logic [LOW_W-1:0] lowCnt;
  logic [FREQ_W-1:0] capt, pend;
  logic pendValid;
  logic frameStart, frameDone;
  logic [(NUM_BYTES-1)*BYTE_W-1:0] stageFlat;

  assign mode     = modeT'(modeSel);
  assign isRtc    = (mode == MODE_RTC);
  assign isRst    = (mode == MODE_SCRESET);
  assign fallEdge = prevPin & ~serialPin;
  assign riseEdge = ~prevPin & serialPin;

  // staged low bytes of the increment, one lane per register
  for (genvar g = 0; g < NUM_BYTES - 1; g++) begin : g_lane
    logic [BYTE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN) laneQ <= '0;
      else if (regWrEn && regAddr == ADDR_W'(g)) laneQ <= regWrData;
    end
    assign stageFlat[g*BYTE_W +: BYTE_W] = laneQ;
  end

  assign frameStart = isRtc && rxState == RX_IDLE && riseEdge && lowCnt == LOW_W'(IDLE_MIN);
  assign frameDone  = rxState == RX_DATA && halfTog && bitIdx == IDX_W'(FRAME_BITS - 1);

  always_comb begin
    str.commit     = regWrEn && regAddr == ADDR_W'(NUM_BYTES - 1);
    str.word       = {regWrData, stageFlat};
    str.phaseClear = isRst && armed && fieldStart;
    str.rtcApply   = isRtc && lineStart && pendValid;
    str.rtcFreq    = pend;
    str.useRtc     = isRtc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPin <= 1'b0;
      armed   <= 1'b0;
    end else begin
      prevPin <= serialPin;
      if (!isRst)              armed <= 1'b0;
      else if (fallEdge)       armed <= 1'b1;
      else if (str.phaseClear) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState   <= RX_IDLE;
      halfTog   <= 1'b0;
      bitIdx    <= '0;
      lowCnt    <= '0;
      capt      <= '0;
      pend      <= '0;
      pendValid <= 1'b0;
    end else if (!isRtc) begin
      rxState   <= RX_IDLE;
      lowCnt    <= '0;
      pendValid <= 1'b0;
    end else begin
      if (rxState != RX_IDLE || serialPin) lowCnt <= '0;
      else if (lowCnt != LOW_W'(IDLE_MIN)) lowCnt <= lowCnt + 1'b1;
      if (frameDone) begin
        pend      <= capt;
        pendValid <= 1'b1;
      end else if (str.rtcApply) begin
        pendValid <= 1'b0;
      end
      unique case (rxState)
        RX_IDLE:  if (frameStart) rxState <= RX_START;
        RX_START: begin
          rxState <= RX_DATA;
          halfTog <= 1'b0;
          bitIdx  <= '0;
        end
        default: begin
          if (!halfTog) halfTog <= 1'b1;
          else begin
            halfTog <= 1'b0;
            if (bitIdx < IDX_W'(FREQ_W)) capt[bitIdx[FIDX_W-1:0]] <= serialPin;
            if (frameDone) rxState <= RX_IDLE;
            else bitIdx <= bitIdx + 1'b1;
          end
        end
      endcase
    end
  end

  // R7
  arm_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRst && fallEdge) |=> (armed || !isRst));
  // R10
  short_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_IDLE && riseEdge && lowCnt < LOW_W'(IDLE_MIN)) |=> rxState == RX_IDLE);
  // R8
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_DATA) |-> bitIdx < IDX_W'(FRAME_BITS));
  // R9
  pend_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (pendValid || !isRtc));
endmodule

// File: rtl/scdds_datapath.sv
module scdds_datapath
  import scdds_pkg::*;
#(
  parameter logic [ACC_W-1:0] RESET_WORD = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           str,
  output logic [ACC_W-1:0] phaseOut
);
  logic [ACC_W-1:0]  progWord;
  logic [FREQ_W-1:0] rtcInc;
  logic              rtcLoaded;
  logic [ACC_W-1:0]  activeInc;
  logic [ACC_W-1:0]  phase;

  assign activeInc = (str.useRtc && rtcLoaded) ? {rtcInc, {PAD_W{1'b0}}} : progWord;
  assign phaseOut  = phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progWord  <= RESET_WORD;
      rtcInc    <= '0;
      rtcLoaded <= 1'b0;
      phase     <= '0;
    end else begin
      if (str.commit) progWord <= str.word;
      if (!str.useRtc) rtcLoaded <= 1'b0;
      else if (str.rtcApply) begin
        rtcLoaded <= 1'b1;
        rtcInc    <= str.rtcFreq;
      end
      phase <= str.phaseClear ? '0 : phase + activeInc;
    end
  end

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.commit |=> $stable(progWord));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.phaseClear |=> phase == '0);
  // R11
  rtc_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.useRtc |-> activeInc == progWord);
  // R9
  apply_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.rtcApply |=> (rtcLoaded || !str.useRtc));
endmodule

// File: rtl/scdds_top.sv
module scdds_top
  import scdds_pkg::*;
#(
  parameter int                IDLE_MIN   = 4,
  parameter int                FRAME_BITS = 67,
  parameter logic [ACC_W-1:0]  RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic [1:0]        modeSel,
  input  logic              serialPin,
  input  logic              fieldStart,
  input  logic              lineStart,
  output logic [ACC_W-1:0]  phaseOut
);
  strobeT str;

  scdds_ctrl #(.IDLE_MIN(IDLE_MIN), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .modeSel(modeSel), .serialPin(serialPin),
    .fieldStart(fieldStart), .lineStart(lineStart), .str(str)
  );

  scdds_datapath #(.RESET_WORD(RESET_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .phaseOut(phaseOut)
  );
endmodule

// File: tb/sim_scdds_top.sv
module sim_scdds_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [1:0]  modeSel = 2'b00;
  logic        serialPin = 1'b0;
  logic        fieldStart = 1'b0;
  logic        lineStart = 1'b0;
  logic [31:0] phaseOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  scdds_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .modeSel(modeSel), .serialPin(serialPin),
    .fieldStart(fieldStart), .lineStart(lineStart), .phaseOut(phaseOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic stepOf(output logic [31:0] d);
    logic [31:0] a;
    a = phaseOut;
    tick();
    d = phaseOut - a;
  endtask

  task automatic expectStep(logic [31:0] exp, string tag);
    logic [31:0] d;
    stepOf(d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic writeWord(logic [31:0] w);
    for (int i = 0; i < 4; i++) writeReg(2'(i), w[i*8 +: 8]);
  endtask

  task automatic pulseLine();
    lineStart = 1'b1; tick(); lineStart = 1'b0;
  endtask

  task automatic sendFrame(logic [21:0] v, int idle);
    serialPin = 1'b0;
    repeat (idle) tick();
    serialPin = 1'b1;
    repeat (2) tick();
    for (int k = 0; k < 67; k++) begin
      serialPin = (k < 22) ? v[k] : k[0];
      repeat (2) tick();
    end
    serialPin = 1'b0;
    tick();
  endtask

  initial begin
    logic [31:0] w, a, b, exp;
    logic [21:0] vals [4];
    vals[0] = 22'h3FFFFF; vals[1] = 22'h000001; vals[2] = 22'h2AAAAA; vals[3] = 22'h155555;

    repeat (3) tick();
    chk(phaseOut == 0, "R1 phase in reset", phaseOut, 0);
    rstN = 1'b1;
    tick();
    chk(phaseOut == 0, "R1 phase after reset", phaseOut, 0);
    expectStep(32'h0, "R1 reset increment");

    // R2: staged bytes do not act
    writeReg(2'd0, 8'h55); writeReg(2'd1, 8'h66); writeReg(2'd2, 8'h77);
    expectStep(32'h0, "R2 staged no effect");
    // R3: commit on address 3
    writeReg(2'd3, 8'h12);
    expectStep(32'h12776655, "R3 commit word");

    // R3/R4 sweep of words including wrap cases
    for (int i = 0; i < 10; i++) begin
      w = (i == 0) ? 32'hFFFFFFFF : (i == 1) ? 32'h80000000 : (i == 2) ? 32'h00000001
                                 : 32'h9E3779B9 * i + 32'h01234567;
      writeWord(w);
      expectStep(w, "R3 swept word");
      a = phaseOut;
      repeat (5) tick();
      exp = a + 32'd5 * w;
      chk(phaseOut == exp, "R4 five-step accumulate", phaseOut, exp);
    end

    // R2 partial restage
    w = 32'hA1B2C3D4;
    writeWord(w);
    writeReg(2'd0, 8'hEE);
    expectStep(w, "R2 byte0 staged only");
    writeReg(2'd3, 8'h3C);
    expectStep(32'h3CB2C3EE, "R3 commit keeps earlier stages");
    w = 32'h3CB2C3EE;

    // R5: normal modes ignore pin and strobes
    for (int m = 0; m < 2; m++) begin
      modeSel = (m == 0) ? 2'b00 : 2'b11;
      serialPin = 1'b1; tick();
      serialPin = 1'b0; tick();
      a = phaseOut;
      fieldStart = 1'b1; lineStart = 1'b1; tick();
      fieldStart = 1'b0; lineStart = 1'b0;
      chk(phaseOut == a + w, "R5 normal mode ignores strobes", phaseOut, a + w);
      expectStep(w, "R5 normal mode step");
    end

    // R6: armed restart
    modeSel = 2'b01;
    serialPin = 1'b1; tick();
    serialPin = 1'b0; tick();
    repeat (4) tick();
    fieldStart = 1'b1; tick(); fieldStart = 1'b0;
    chk(phaseOut == 0, "R6 restart at field", phaseOut, 0);
    tick();
    chk(phaseOut == w, "R6 resume from zero", phaseOut, w);
    a = phaseOut;
    fieldStart = 1'b1; tick(); fieldStart = 1'b0;
    chk(phaseOut == a + w, "R6 unarmed field no effect", phaseOut, a + w);

    // R7: fall in same cycle as field start, not armed
    serialPin = 1'b1; tick();
    a = phaseOut;
    serialPin = 1'b0; fieldStart = 1'b1; tick(); fieldStart = 1'b0;
    chk(phaseOut == a + w, "R7 coincident fall defers", phaseOut, a + w);
    repeat (3) tick();
    fieldStart = 1'b1; tick(); fieldStart = 1'b0;
    chk(phaseOut == 0, "R7 following field restarts", phaseOut, 0);
    // R7: already armed plus new fall at field start
    serialPin = 1'b1; tick();
    serialPin = 1'b0; tick();
    serialPin = 1'b1; tick();
    serialPin = 1'b0; fieldStart = 1'b1; tick(); fieldStart = 1'b0;
    chk(phaseOut == 0, "R7 armed restart fires", phaseOut, 0);
    repeat (2) tick();
    fieldStart = 1'b1; tick(); fieldStart = 1'b0;
    chk(phaseOut == 0, "R7 re-armed by coincident fall", phaseOut, 0);

    // R8/R9: real-time control frames
    modeSel = 2'b10;
    serialPin = 1'b0;
    expectStep(w, "R9 programmed word before frame");
    for (int i = 0; i < 4; i++) begin
      sendFrame(vals[i], 6);
      b = (i == 0) ? w : {vals[i-1], 10'b0};
      expectStep(b, "R9 old increment until line start");
      pulseLine();
      expectStep({vals[i], 10'b0}, "R8 frame value applied");
    end
    pulseLine();
    expectStep({vals[3], 10'b0}, "R9 line start without frame holds");

    // R10: rises after short idle only
    modeSel = 2'b00; serialPin = 1'b1; tick();
    modeSel = 2'b10;
    for (int i = 0; i < 40; i++) begin
      serialPin = 1'b0; repeat (2) tick();
      serialPin = 1'b1; repeat (2) tick();
    end
    pulseLine();
    expectStep(w, "R10 short idle starts no frame");

    // R11: leaving mode drops pending and applied values
    sendFrame(22'h0ABCDE, 5);
    modeSel = 2'b00;
    expectStep(w, "R11 leave restores word");
    modeSel = 2'b10;
    pulseLine();
    expectStep(w, "R11 pending discarded");
    sendFrame(22'h12345, 4);
    pulseLine();
    expectStep({22'h12345, 10'b0}, "R8 minimum idle frame");
    modeSel = 2'b11;
    expectStep(w, "R11 applied value dropped");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule